// File: doc/BRIEF.md
# Branch Squash Controller (Predict Not-Taken)

This block is the control-hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Fetch runs straight down the sequential path as if every conditional branch falls through. A branch-if-equal computes its target and its equality result in execute. Both are registered into the EX/MEM stage register, and the controller acts on them while the branch sits there. A branch that falls through costs nothing. A taken branch makes the controller steer the program counter to the target. In the same cycle it kills the three younger instructions: the one being fetched, the one in IF/ID, and the one in ID/EX. Each of these is turned into a noop as it moves to the next stage register.

The controller also arbitrates between redirection and the stall request from the data-hazard unit. It tells that unit which decode-side instructions are still live producers. A small flow machine tracks the refill after a redirect. Its states are OPEN (normal flow, redirect allowed), DRAIN1, DRAIN2 and DRAIN3 (the three cycles in which EX/MEM holds squashed slots). Its transitions are OPEN to DRAIN1 on a redirect, DRAIN1 to DRAIN2, DRAIN2 to DRAIN3, and DRAIN3 to OPEN, all unconditional apart from the first. OPEN stays in OPEN without a redirect. Reset puts the machine in OPEN.

Top module: `branch_squash_ctl`

## Requirements
- R1: When the machine is in OPEN and EX/MEM holds a valid instruction whose 3-bit opcode is 3'b100 (branch-if-equal) with its equality flag set, pc_sel is 2'b10 and next_pc equals exmem_target in that same cycle.
- R2: When EX/MEM holds a branch whose equality flag is clear, or an instruction with any other opcode, and no stall is requested, pc_sel is 2'b00, next_pc is pc_cur + 1 (modulo 2^16) and all squash bits are 0.
- R3: Squash bit 0 (the instruction being fetched) is 1 in every redirect cycle. Bit 1 (the IF/ID slot) equals ifid_valid in a redirect cycle, and bit 2 (the ID/EX slot) equals idex_valid. Outside redirect cycles all squash bits are 0.
- R4: A redirect takes priority over a simultaneous stall_req: pc_sel is 2'b10 and stall_out is 0.
- R5: With stall_req high and no redirect, pc_sel is 2'b01, next_pc equals pc_cur and stall_out is 1.
- R6: A taken-looking branch in EX/MEM with exmem_valid low causes no redirect.
- R7: In the three cycles after a redirect (DRAIN1 to DRAIN3), no redirect is issued whatever EX/MEM presents. A taken branch in the fourth cycle redirects again.
- R8: hz_live bit 0 equals ifid_valid and bit 1 equals idex_valid, except in a redirect cycle, when both are 0.
- R9: Out of reset the machine is in OPEN: with an idle EX/MEM and no stall, pc_sel is 2'b00 and next_pc is pc_cur + 1.
- R10: In a pipeline driven by the controller, the order of retired instructions and the final register contents match an in-order execution of the same program, with and without random stall requests.
- R11: Without stalls, a not-taken branch adds no empty writeback cycle, and each taken branch adds exactly three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_cur | input | 16 | Current fetch address |
| stall_req | input | 1 | Stall request from the data-hazard unit |
| ifid_valid | input | 1 | IF/ID holds a live instruction |
| idex_valid | input | 1 | ID/EX holds a live instruction |
| exmem_valid | input | 1 | EX/MEM holds a live instruction |
| exmem_op | input | 3 | Opcode in EX/MEM (3'b100 is branch-if-equal) |
| exmem_eq | input | 1 | Equality result computed in execute |
| exmem_target | input | 16 | Branch target computed in execute |
| pc_sel | output | 2 | 00 sequential, 01 hold, 10 branch target |
| next_pc | output | 16 | Address for the next fetch |
| squash | output | 3 | Per-slot noop strobes: bit0 fetch, bit1 IF/ID, bit2 ID/EX |
| stall_out | output | 1 | Stall actually applied (hold PC and IF/ID, bubble into ID/EX) |
| hz_live | output | 2 | Live hazard producers: bit0 IF/ID, bit1 ID/EX |

## Verification
The bench aims at a taken branch that arrives together with a stall request. A design that let the stall win would hold the wrong PC and let the killed instructions run on. It applies taken-looking branches during the three refill cycles. A controller without the flow machine would redirect on stale state, and one with a short refill count would reopen a cycle early. It squashes with only some slots valid, so that a design strobing the wrong bit or ignoring the valid bits shows up. End-to-end runs compare the retired instruction stream and the register file against an in-order model. A missed squash then shows up as an extra retirement, and a wrong penalty as a wrong writeback span.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    // program-counter source, encoding is visible on the pc_sel port
    typedef enum logic [1:0] {
        PCSEL_SEQ    = 2'b00,
        PCSEL_HOLD   = 2'b01,
        PCSEL_TARGET = 2'b10
    } pc_sel_e;

    // refill tracking after a redirect
    typedef enum logic [1:0] {
        ST_OPEN   = 2'b00,
        ST_DRAIN1 = 2'b01,
        ST_DRAIN2 = 2'b10,
        ST_DRAIN3 = 2'b11
    } flow_e;

    // fetch slot, IF/ID slot, ID/EX slot
    localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/bsq_resolve.sv
module bsq_resolve #(
    parameter int OP_W     = 3,
    parameter int PC_W     = 16,
    parameter logic [OP_W-1:0] BEQ_CODE = 3'b100
) (
    input  logic            exmem_valid,
    input  logic [OP_W-1:0] exmem_op,
    input  logic            exmem_eq,
    input  logic [PC_W-1:0] exmem_target,
    output logic            take,
    output logic [PC_W-1:0] take_target
);

    logic is_branch;

    always_comb begin
        is_branch   = exmem_valid && (exmem_op == BEQ_CODE);
        take        = is_branch && exmem_eq;
        take_target = exmem_target;
    end

endmodule

// File: rtl/bsq_fsm.sv
module bsq_fsm
    import bsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic redirect
);

    flow_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        redirect  = 1'b0;
        state_nxt = state;
        unique case (state)
            ST_OPEN: begin
                if (take) begin
                    redirect  = 1'b1;
                    state_nxt = ST_DRAIN1;
                end
            end
            ST_DRAIN1: state_nxt = ST_DRAIN2;
            ST_DRAIN2: state_nxt = ST_DRAIN3;
            ST_DRAIN3: state_nxt = ST_OPEN;
        endcase
    end

    // R7
    drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!redirect && state == ST_DRAIN1));

    // R7
    drain_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN2) |=> (state == ST_DRAIN3));

endmodule

// File: rtl/bsq_squash.sv
module bsq_squash #(
    parameter int NSLOT = 3
) (
    input  logic             redirect,
    input  logic [NSLOT-1:0] slot_valid,
    output logic [NSLOT-1:0] squash,
    output logic [NSLOT-2:0] hz_live
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_kill
        assign squash[g] = redirect & slot_valid[g];
    end

    for (genvar h = 1; h < NSLOT; h++) begin : g_live
        assign hz_live[h-1] = slot_valid[h] & ~redirect;
    end

endmodule

// File: rtl/branch_squash_ctl.sv
module branch_squash_ctl
    import bsq_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int OP_W = 3,
    parameter logic [OP_W-1:0] BEQ_CODE = 3'b100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_W-1:0]      pc_cur,
    input  logic                 stall_req,
    input  logic                 ifid_valid,
    input  logic                 idex_valid,
    input  logic                 exmem_valid,
    input  logic [OP_W-1:0]      exmem_op,
    input  logic                 exmem_eq,
    input  logic [PC_W-1:0]      exmem_target,
    output logic [1:0]           pc_sel,
    output logic [PC_W-1:0]      next_pc,
    output logic [NUM_SLOTS-1:0] squash,
    output logic                 stall_out,
    output logic [NUM_SLOTS-2:0] hz_live
);

    logic            take;
    logic [PC_W-1:0] take_target;
    logic            redirect;
    pc_sel_e         sel;

    bsq_resolve #(
        .OP_W     (OP_W),
        .PC_W     (PC_W),
        .BEQ_CODE (BEQ_CODE)
    ) u_resolve (
        .exmem_valid  (exmem_valid),
        .exmem_op     (exmem_op),
        .exmem_eq     (exmem_eq),
        .exmem_target (exmem_target),
        .take         (take),
        .take_target  (take_target)
    );

    bsq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .redirect (redirect)
    );

    bsq_squash #(
        .NSLOT (NUM_SLOTS)
    ) u_squash (
        .redirect   (redirect),
        .slot_valid ({idex_valid, ifid_valid, 1'b1}),
        .squash     (squash),
        .hz_live    (hz_live)
    );

    always_comb begin
        if (redirect) begin
            sel = PCSEL_TARGET;
        end else if (stall_req) begin
            sel = PCSEL_HOLD;
        end else begin
            sel = PCSEL_SEQ;
        end
        stall_out = stall_req & ~redirect;
    end

    always_comb begin
        next_pc = pc_cur + PC_W'(1);
        unique case (sel)
            PCSEL_TARGET: next_pc = take_target;
            PCSEL_HOLD:   next_pc = pc_cur;
            default:      next_pc = pc_cur + PC_W'(1);
        endcase
        pc_sel = sel;
    end

    // R1
    target_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == PCSEL_TARGET) |-> (next_pc == exmem_target));

    // R3
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel != PCSEL_TARGET) |-> (squash == '0));

    // R4
    stall_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == PCSEL_TARGET) |-> !stall_out);

    // R5
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == PCSEL_HOLD) |-> (next_pc == pc_cur && stall_out));

    // R6
    invalid_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exmem_valid |-> (pc_sel != PCSEL_TARGET));

endmodule

// File: tb/test_branch_squash_ctl.sv
`timescale 1ns/1ps
module test_branch_squash_ctl;

    localparam int NPROG = 40;
    localparam logic [2:0] OP_BEQ = 3'b100;
    localparam logic [2:0] OP_ADD = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_cur = 16'h0100;
    logic        stall_req = 1'b0;
    logic        ifid_valid = 1'b0;
    logic        idex_valid = 1'b0;
    logic        exmem_valid = 1'b0;
    logic [2:0]  exmem_op = 3'b000;
    logic        exmem_eq = 1'b0;
    logic [15:0] exmem_target = 16'h0000;
    logic [1:0]  pc_sel;
    logic [15:0] next_pc;
    logic [2:0]  squash;
    logic        stall_out;
    logic [1:0]  hz_live;

    always #5 clk = ~clk;

    branch_squash_ctl i_branch_squash_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_cur       (pc_cur),
        .stall_req    (stall_req),
        .ifid_valid   (ifid_valid),
        .idex_valid   (idex_valid),
        .exmem_valid  (exmem_valid),
        .exmem_op     (exmem_op),
        .exmem_eq     (exmem_eq),
        .exmem_target (exmem_target),
        .pc_sel       (pc_sel),
        .next_pc      (next_pc),
        .squash       (squash),
        .stall_out    (stall_out),
        .hz_live      (hz_live)
    );

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [1:0]  sel;
        logic [15:0] npc;
        logic [2:0]  sq;
        logic        so;
        logic [1:0]  live;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // driver: applies one cycle of stimulus and queues what the outputs must be
    task automatic drive(input logic ev, input logic [2:0] op, input logic eq,
                         input logic [15:0] tgt, input logic st, input logic iv,
                         input logic dv, input logic [1:0] e_sel, input logic [15:0] e_npc,
                         input logic [2:0] e_sq, input logic e_so, input logic [1:0] e_live,
                         input string req);
        exp_t e;
        @(posedge clk); #1;
        exmem_valid = ev; exmem_op = op; exmem_eq = eq; exmem_target = tgt;
        stall_req = st; ifid_valid = iv; idex_valid = dv;
        e.sel = e_sel; e.npc = e_npc; e.sq = e_sq; e.so = e_so; e.live = e_live; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (pc_sel !== e.sel || next_pc !== e.npc || squash !== e.sq ||
                stall_out !== e.so || hz_live !== e.live) begin
                n_fails++;
                $display("FAIL %s sel/npc/sq/so/live act=%b/%h/%b/%b/%b exp=%b/%h/%b/%b/%b",
                         e.req, pc_sel, next_pc, squash, stall_out, hz_live,
                         e.sel, e.npc, e.sq, e.so, e.live);
            end
        end
    end

    // ---------------- end-to-end pipeline model ----------------
    bit        p_br  [NPROG];
    bit        p_eq  [NPROG];
    int        p_tgt [NPROG];
    int        p_rd  [NPROG];
    int        p_imm [NPROG];
    int        rf_ref[8];
    int        rf_dut[8];
    int        ret_q[$];
    int unsigned rs;

    function automatic int unsigned rnd();
        rs ^= rs << 13;
        rs ^= rs >> 17;
        rs ^= rs << 5;
        return rs;
    endfunction

    task automatic check_eq(input int act, input int expv, input string what);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s act=%0d exp=%0d", what, act, expv);
        end
    endtask

    task automatic run_prog(input bit stall_en, input int unsigned seed);
        int pc_r, ifid_pc, idex_pc, exm_pc;
        bit ifid_v, idex_v, exm_v;
        int taken, retired, first_c, last_c;
        logic [1:0] s_sel; logic [15:0] s_npc; logic [2:0] s_sq; logic s_so;
        int ip;
        rs = seed;
        for (int i = 0; i < NPROG; i++) begin
            int unsigned r;
            r = rnd();
            p_br[i]  = (r % 3 == 0) && (i < NPROG - 1);
            p_eq[i]  = r[4];
            p_tgt[i] = i + 2 + int'((r >> 8) % 3);
            if (p_tgt[i] > NPROG - 1) p_tgt[i] = NPROG - 1;
            p_rd[i]  = int'((r >> 12) % 8);
            p_imm[i] = int'((r >> 16) & 8'hff) + 1;
        end
        for (int k = 0; k < 8; k++) begin rf_ref[k] = 0; rf_dut[k] = 0; end
        // in-order reference walk
        taken = 0; ip = 0;
        while (ip < NPROG) begin
            ret_q.push_back(ip);
            if (p_br[ip] && p_eq[ip]) begin
                taken++; ip = p_tgt[ip];
            end else begin
                if (!p_br[ip]) rf_ref[p_rd[ip]] = p_imm[ip];
                ip++;
            end
        end
        pc_r = 0; ifid_v = 0; idex_v = 0; exm_v = 0;
        ifid_pc = 0; idex_pc = 0; exm_pc = 0;
        retired = 0; first_c = -1; last_c = -1;
        s_sel = '0; s_npc = '0; s_sq = '0; s_so = 1'b0;
        for (int cyc = 0; cyc < 800; cyc++) begin
            @(posedge clk); #1;
            if (cyc > 0) begin
                // writeback of the instruction leaving EX/MEM (R10)
                if (exm_v) begin
                    if (first_c < 0) first_c = cyc;
                    last_c = cyc;
                    retired++;
                    if (ret_q.size() == 0) begin
                        n_checks++; n_fails++;
                        $display("FAIL R10 extra retire act=%0d exp=none", exm_pc);
                    end else begin
                        check_eq(exm_pc, ret_q.pop_front(), "R10 retire order pc");
                    end
                    if (!p_br[exm_pc]) rf_dut[p_rd[exm_pc]] = p_imm[exm_pc];
                end
                exm_v  = idex_v && !s_sq[2];
                exm_pc = idex_pc;
                idex_v = ifid_v && !s_sq[1] && !s_so;
                idex_pc = ifid_pc;
                if (!s_so) begin
                    ifid_v  = (pc_r < NPROG) && !s_sq[0];
                    ifid_pc = pc_r;
                end
                pc_r = int'(s_npc);
                if (pc_r >= NPROG && !ifid_v && !idex_v && !exm_v) break;
            end
            pc_cur       = 16'(pc_r);
            ifid_valid   = ifid_v;
            idex_valid   = idex_v;
            exmem_valid  = exm_v;
            exmem_op     = (exm_v && p_br[exm_pc]) ? OP_BEQ : OP_ADD;
            exmem_eq     = exm_v ? p_eq[exm_pc] : 1'b0;
            exmem_target = exm_v ? 16'(p_tgt[exm_pc]) : 16'h0;
            stall_req    = stall_en ? ((rnd() & 3) == 0) : 1'b0;
            @(negedge clk);
            s_sel = pc_sel; s_npc = next_pc; s_sq = squash; s_so = stall_out;
        end
        check_eq(ret_q.size(), 0, "R10 instructions left unretired");
        ret_q.delete();
        for (int k = 0; k < 8; k++) check_eq(rf_dut[k], rf_ref[k], "R10 register value");
        if (!stall_en) begin
            // R11: writeback span equals retirements plus three per taken branch
            check_eq(last_c - first_c + 1, retired + 3 * taken, "R11 writeback span");
        end
        stall_req = 1'b0; exmem_valid = 1'b0; ifid_valid = 1'b0; idex_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        report();
    end

    initial begin
        // R9: state during reset and right after release
        @(posedge clk); #1;
        begin
            exp_t e;
            e.sel = 2'b00; e.npc = 16'h0101; e.sq = 3'b000; e.so = 1'b0; e.live = 2'b00; e.req = "R9";
            exp_q.push_back(e);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        drive(1'b0, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b00, "R9");
        // R2: non-branch with eq set; branch with eq clear
        drive(1'b1, OP_ADD, 1'b1, 16'h0555, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b01, "R2");
        drive(1'b1, OP_BEQ, 1'b0, 16'h0555, 1'b0, 1'b0, 1'b1, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b10, "R2");
        // R5: stall with a not-taken branch
        drive(1'b1, OP_BEQ, 1'b0, 16'h0555, 1'b1, 1'b1, 1'b1, 2'b01, 16'h0100, 3'b000, 1'b1, 2'b11, "R5");
        // R6: invalid slot with a taken-looking branch
        drive(1'b0, OP_BEQ, 1'b1, 16'h0555, 1'b0, 1'b1, 1'b1, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b11, "R6");
        // R1 R3 R4 R8: taken, stall ignored, only IF/ID valid
        drive(1'b1, OP_BEQ, 1'b1, 16'h0234, 1'b1, 1'b1, 1'b0, 2'b10, 16'h0234, 3'b011, 1'b0, 2'b00, "R1_R3_R4_R8");
        // R7: three refill cycles block a taken-looking branch
        drive(1'b1, OP_BEQ, 1'b1, 16'h0777, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b00, "R7");
        drive(1'b1, OP_BEQ, 1'b1, 16'h0777, 1'b1, 1'b0, 1'b0, 2'b01, 16'h0100, 3'b000, 1'b1, 2'b00, "R7");
        drive(1'b1, OP_BEQ, 1'b1, 16'h0777, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b01, "R7");
        // R7 R3: fourth cycle redirects again, only ID/EX valid
        drive(1'b1, OP_BEQ, 1'b1, 16'h0888, 1'b0, 1'b0, 1'b1, 2'b10, 16'h0888, 3'b101, 1'b0, 2'b00, "R7_R3");
        drive(1'b0, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b11, "R8");
        drive(1'b0, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b11, "R8");
        drive(1'b0, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b11, "R8");
        // R3 R8: all slots valid
        drive(1'b1, OP_BEQ, 1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b1, 2'b10, 16'hFFFF, 3'b111, 1'b0, 2'b00, "R3_R8");
        drive(1'b0, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b00, "R2");
        drive(1'b0, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b00, "R2");
        drive(1'b0, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0101, 3'b000, 1'b0, 2'b00, "R2");
        @(negedge clk);
        @(negedge clk);
        // R10 R11: programs with branches, without and with stalls
        run_prog(1'b0, 32'h1234_5678);
        run_prog(1'b0, 32'h0BAD_F00D);
        run_prog(1'b1, 32'h7777_1111);
        run_prog(1'b1, 32'h2468_ACE1);
        @(negedge clk);
        report();
    end

endmodule